// File: doc/BRIEF.md
# Multi-mode NTT butterfly unit

This block is the arithmetic core of a lattice polynomial multiplier. Each cycle it takes up to four coefficients, a twiddle factor, an operation select and a modulus select. A fixed number of cycles later it returns two coefficients reduced into the range of the chosen prime. A single pipeline handles three jobs:

- the Cooley–Tukey style forward butterfly;
- the inverse butterfly, which also halves its results;
- pointwise multiplication, either as one product or as the paired degree-one product used by the 3329 scheme.

Three primes are built in: 3329, 8380417 and 12289. Coefficients are up to 23 bits wide. Every modular product uses a Barrett estimate with k = 2·ceil(log2 q), followed by one conditional subtraction of q. Address generation, coefficient memories, twiddle storage and floating-point arithmetic stay in the surrounding datapath. The unit accepts a new operation every cycle, with no stalls.

Top module: `ntt_bfly_unit`

## Requirements
- R1: Operation code 0 (forward): out_c0 = (a0 + a1·w) mod q and out_c1 = (a0 − a1·w) mod q.
- R2: Operation code 1 (inverse): out_c0 = (a0 + a1)·2⁻¹ mod q and out_c1 = w·(a0 − a1)·2⁻¹ mod q.
- R3: Operation code 2 (single product): out_c0 = a0·b0 mod q and out_c1 = 0.
- R4: Operation code 3 (paired product): out_c0 = (a0·b0 + a1·b1·w) mod q and out_c1 = (a0·b1 + a1·b0) mod q.
- R5: Modulus select 0 picks q = 3329, 1 picks q = 8380417, 2 picks q = 12289, and 3 behaves exactly like 0.
- R6: Every operation accepted with in_vld high appears on the outputs with out_vld high exactly 4 clock edges later, with one operation per cycle and back-to-back issue allowed.
- R7: When all inputs are below the selected q, every result shown with out_vld high is also below q.
- R8: While rst_n is low, and on the first sampling after it, out_vld is 0 whatever in_vld does, and operations already in the pipeline are discarded.
- R9: A cycle with in_vld low produces a cycle with out_vld low 4 edges later, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operation present this cycle |
| in_mode | input | 2 | 0 forward, 1 inverse, 2 single product, 3 paired product |
| in_qsel | input | 2 | Modulus select (see R5) |
| in_a0 | input | 23 | First coefficient (butterfly upper input) |
| in_a1 | input | 23 | Second coefficient (butterfly lower input) |
| in_b0 | input | 23 | First multiplicand coefficient for pointwise modes |
| in_b1 | input | 23 | Second multiplicand coefficient for paired mode |
| in_w | input | 23 | Twiddle factor |
| out_vld | output | 1 | Result present this cycle |
| out_c0 | output | 23 | First reduced result |
| out_c1 | output | 23 | Second reduced result |

## Verification
The assertions check on every cycle that each stage's valid bit follows the one before it. They also check that the operands, the Barrett product and the final results stay below the modulus carried with them, and that a single product leaves a zero in the second result. Arithmetic correctness can only be shown by the bench's scenarios. These compare each result against a separate remainder-based model, covering edge values near q−1, odd and even halving, every modulus including the alias code, idle gaps and a reset in the middle of a stream.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int CW = 23;
  localparam int PW = 2 * CW;
  localparam int XW = 80;

  typedef enum logic [1:0] {
    MD_FWD  = 2'd0,
    MD_INV  = 2'd1,
    MD_MUL  = 2'd2,
    MD_PAIR = 2'd3
  } mode_e;

  localparam logic [CW-1:0] Q_A = 23'd3329;
  localparam logic [CW-1:0] Q_B = 23'd8380417;
  localparam logic [CW-1:0] Q_C = 23'd12289;
  localparam int K_A = 24;
  localparam int K_B = 46;
  localparam int K_C = 28;
  localparam logic [XW-1:0] M_A = (80'd1 << K_A) / XW'(Q_A);
  localparam logic [XW-1:0] M_B = (80'd1 << K_B) / XW'(Q_B);
  localparam logic [XW-1:0] M_C = (80'd1 << K_C) / XW'(Q_C);

  function automatic logic [CW-1:0] mod_q(input logic [1:0] sel);
    case (sel)
      2'd1:    return Q_B;
      2'd2:    return Q_C;
      default: return Q_A;
    endcase
  endfunction

  function automatic logic [6:0] mod_k(input logic [1:0] sel);
    case (sel)
      2'd1:    return 7'(K_B);
      2'd2:    return 7'(K_C);
      default: return 7'(K_A);
    endcase
  endfunction

  function automatic logic [XW-1:0] mod_m(input logic [1:0] sel);
    case (sel)
      2'd1:    return M_B;
      2'd2:    return M_C;
      default: return M_A;
    endcase
  endfunction

  // sum of two residues, one conditional correction
  function automatic logic [CW-1:0] mod_add(input logic [CW-1:0] a, input logic [CW-1:0] b,
                                            input logic [CW-1:0] q);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, q}) s = s - {1'b0, q};
    return s[CW-1:0];
  endfunction

  function automatic logic [CW-1:0] mod_sub(input logic [CW-1:0] a, input logic [CW-1:0] b,
                                            input logic [CW-1:0] q);
    logic [CW:0] d;
    d = {1'b0, a} + {1'b0, q} - {1'b0, b};
    if (d >= {1'b0, q}) d = d - {1'b0, q};
    return d[CW-1:0];
  endfunction

  // division by two: make the value even by adding q, then shift
  function automatic logic [CW-1:0] mod_half(input logic [CW-1:0] v, input logic [CW-1:0] q);
    logic [CW:0] s;
    s = v[0] ? ({1'b0, v} + {1'b0, q}) : {1'b0, v};
    return s[CW:1];
  endfunction

  // Barrett: t = (p*m)>>k, r = p - t*q, at most one more subtraction
  function automatic logic [CW-1:0] mod_mul(input logic [CW-1:0] a, input logic [CW-1:0] b,
                                            input logic [1:0] sel);
    logic [CW-1:0] q;
    logic [PW-1:0] p;
    logic [XW-1:0] t;
    logic [XW-1:0] r;
    q = mod_q(sel);
    p = PW'(a) * PW'(b);
    t = (XW'(p) * mod_m(sel)) >> mod_k(sel);
    r = XW'(p) - t * XW'(q);
    if (r >= XW'(q)) r = r - XW'(q);
    return r[CW-1:0];
  endfunction
endpackage

// File: rtl/bfly_pre.sv
module bfly_pre
  import bfly_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [1:0]    in_mode,
  input  logic [1:0]    in_qsel,
  input  logic [CW-1:0] in_a0,
  input  logic [CW-1:0] in_a1,
  input  logic [CW-1:0] in_b0,
  input  logic [CW-1:0] in_b1,
  input  logic [CW-1:0] in_w,
  output logic          s1_vld,
  output logic [1:0]    s1_mode,
  output logic [1:0]    s1_qsel,
  output logic [CW-1:0] s1_x,
  output logic [CW-1:0] s1_y,
  output logic [CW-1:0] s1_u,
  output logic [CW-1:0] s1_v
);
  logic [CW-1:0] q_in;
  logic [CW-1:0] sum_raw, dif_raw, sum_half, dif_half;
  logic [CW-1:0] prod_ll, prod_hh, prod_lh, prod_hl, cross_sum;
  logic          sum_odd, dif_odd;
  logic [CW-1:0] nx_x, nx_y, nx_u, nx_v;

  assign q_in      = mod_q(in_qsel);
  assign sum_raw   = mod_add(in_a0, in_a1, q_in);
  assign dif_raw   = mod_sub(in_a0, in_a1, q_in);
  assign sum_odd   = sum_raw[0];
  assign dif_odd   = dif_raw[0];
  assign sum_half  = mod_half(sum_raw, q_in);
  assign dif_half  = mod_half(dif_raw, q_in);
  assign prod_ll   = mod_mul(in_a0, in_b0, in_qsel);
  assign prod_hh   = mod_mul(in_a1, in_b1, in_qsel);
  assign prod_lh   = mod_mul(in_a0, in_b1, in_qsel);
  assign prod_hl   = mod_mul(in_a1, in_b0, in_qsel);
  assign cross_sum = mod_add(prod_lh, prod_hl, q_in);

  always_comb begin
    nx_x = in_a1;
    nx_y = in_w;
    nx_u = in_a0;
    nx_v = '0;
    case (in_mode)
      MD_FWD: begin
        nx_x = in_a1;  nx_y = in_w;  nx_u = in_a0;    nx_v = '0;
      end
      MD_INV: begin
        nx_x = dif_half; nx_y = in_w; nx_u = sum_half; nx_v = '0;
      end
      MD_MUL: begin
        nx_x = in_a0;  nx_y = in_b0; nx_u = '0;       nx_v = '0;
      end
      default: begin
        nx_x = prod_hh; nx_y = in_w; nx_u = prod_ll;  nx_v = cross_sum;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_mode <= '0;
      s1_qsel <= '0;
      s1_x    <= '0;
      s1_y    <= '0;
      s1_u    <= '0;
      s1_v    <= '0;
    end else begin
      s1_vld  <= in_vld;
      s1_mode <= in_mode;
      s1_qsel <= in_qsel;
      s1_x    <= nx_x;
      s1_y    <= nx_y;
      s1_u    <= nx_u;
      s1_v    <= nx_v;
    end
  end

  // R2: halving of an odd residue must yield a value below q
  p_half_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_mode == MD_INV && in_a0 < q_in && in_a1 < q_in && (sum_odd || dif_odd))
      |-> (sum_half < q_in && dif_half < q_in));

  // R7: first-stage operands stay below the modulus carried with them
  p_op_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> (s1_x < mod_q(s1_qsel) && s1_u < mod_q(s1_qsel) && s1_v < mod_q(s1_qsel)));
endmodule

// File: rtl/bfly_mul.sv
module bfly_mul
  import bfly_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s1_vld,
  input  logic [1:0]    s1_mode,
  input  logic [1:0]    s1_qsel,
  input  logic [CW-1:0] s1_x,
  input  logic [CW-1:0] s1_y,
  input  logic [CW-1:0] s1_u,
  input  logic [CW-1:0] s1_v,
  output logic          s2_vld,
  output logic [1:0]    s2_mode,
  output logic [1:0]    s2_qsel,
  output logic [CW-1:0] s2_p,
  output logic [CW-1:0] s2_u,
  output logic [CW-1:0] s2_v
);
  logic [CW-1:0] prod;

  assign prod = mod_mul(s1_x, s1_y, s1_qsel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld  <= 1'b0;
      s2_mode <= '0;
      s2_qsel <= '0;
      s2_p    <= '0;
      s2_u    <= '0;
      s2_v    <= '0;
    end else begin
      s2_vld  <= s1_vld;
      s2_mode <= s1_mode;
      s2_qsel <= s1_qsel;
      s2_p    <= prod;
      s2_u    <= s1_u;
      s2_v    <= s1_v;
    end
  end

  // R6: valid advances one stage per edge
  p_vld_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s2_vld == $past(s1_vld));

  // R7: the Barrett product is fully reduced
  p_prod_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s2_vld |-> (s2_p < mod_q(s2_qsel)));
endmodule

// File: rtl/bfly_post.sv
module bfly_post
  import bfly_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s2_vld,
  input  logic [1:0]    s2_mode,
  input  logic [1:0]    s2_qsel,
  input  logic [CW-1:0] s2_p,
  input  logic [CW-1:0] s2_u,
  input  logic [CW-1:0] s2_v,
  output logic          out_vld,
  output logic [CW-1:0] out_c0,
  output logic [CW-1:0] out_c1
);
  logic [CW-1:0] q2, q3;
  logic          s3_vld;
  logic [1:0]    s3_mode, s3_qsel, s4_mode, s4_qsel;
  logic [CW:0]   s3_raw0, s3_raw1, nx_raw0, nx_raw1;
  logic          over0, over1;
  logic [CW:0]   fix0, fix1;

  assign q2 = mod_q(s2_qsel);

  always_comb begin
    nx_raw0 = {1'b0, s2_u} + {1'b0, s2_p};
    nx_raw1 = {1'b0, s2_u} + {1'b0, q2} - {1'b0, s2_p};
    case (s2_mode)
      MD_FWD: begin
        nx_raw0 = {1'b0, s2_u} + {1'b0, s2_p};
        nx_raw1 = {1'b0, s2_u} + {1'b0, q2} - {1'b0, s2_p};
      end
      MD_INV: begin
        nx_raw0 = {1'b0, s2_u};
        nx_raw1 = {1'b0, s2_p};
      end
      MD_MUL: begin
        nx_raw0 = {1'b0, s2_p};
        nx_raw1 = '0;
      end
      default: begin
        nx_raw0 = {1'b0, s2_u} + {1'b0, s2_p};
        nx_raw1 = {1'b0, s2_v};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_vld  <= 1'b0;
      s3_mode <= '0;
      s3_qsel <= '0;
      s3_raw0 <= '0;
      s3_raw1 <= '0;
    end else begin
      s3_vld  <= s2_vld;
      s3_mode <= s2_mode;
      s3_qsel <= s2_qsel;
      s3_raw0 <= nx_raw0;
      s3_raw1 <= nx_raw1;
    end
  end

  // final correction: raw values are below 2q
  assign q3    = mod_q(s3_qsel);
  assign over0 = s3_raw0 >= {1'b0, q3};
  assign over1 = s3_raw1 >= {1'b0, q3};
  assign fix0  = over0 ? s3_raw0 - {1'b0, q3} : s3_raw0;
  assign fix1  = over1 ? s3_raw1 - {1'b0, q3} : s3_raw1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      s4_mode <= '0;
      s4_qsel <= '0;
      out_c0  <= '0;
      out_c1  <= '0;
    end else begin
      out_vld <= s3_vld;
      s4_mode <= s3_mode;
      s4_qsel <= s3_qsel;
      out_c0  <= fix0[CW-1:0];
      out_c1  <= fix1[CW-1:0];
    end
  end

  // R6: the last two stages keep the valid bit in step
  p_out_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(s3_vld));

  // R7: results leave fully reduced
  p_out_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_c0 < mod_q(s4_qsel) && out_c1 < mod_q(s4_qsel)));

  // R3: a single product leaves the second result at zero
  p_plain_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && s4_mode == MD_MUL) |-> (out_c1 == '0));
endmodule

// File: rtl/ntt_bfly_unit.sv
module ntt_bfly_unit
  import bfly_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [1:0]    in_mode,
  input  logic [1:0]    in_qsel,
  input  logic [CW-1:0] in_a0,
  input  logic [CW-1:0] in_a1,
  input  logic [CW-1:0] in_b0,
  input  logic [CW-1:0] in_b1,
  input  logic [CW-1:0] in_w,
  output logic          out_vld,
  output logic [CW-1:0] out_c0,
  output logic [CW-1:0] out_c1
);
  logic          s1_vld, s2_vld;
  logic [1:0]    s1_mode, s1_qsel, s2_mode, s2_qsel;
  logic [CW-1:0] s1_x, s1_y, s1_u, s1_v;
  logic [CW-1:0] s2_p, s2_u, s2_v;

  bfly_pre u_pre (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_mode(in_mode), .in_qsel(in_qsel),
    .in_a0(in_a0), .in_a1(in_a1), .in_b0(in_b0), .in_b1(in_b1), .in_w(in_w),
    .s1_vld(s1_vld), .s1_mode(s1_mode), .s1_qsel(s1_qsel),
    .s1_x(s1_x), .s1_y(s1_y), .s1_u(s1_u), .s1_v(s1_v)
  );

  bfly_mul u_mul (
    .clk(clk), .rst_n(rst_n), .s1_vld(s1_vld), .s1_mode(s1_mode), .s1_qsel(s1_qsel),
    .s1_x(s1_x), .s1_y(s1_y), .s1_u(s1_u), .s1_v(s1_v),
    .s2_vld(s2_vld), .s2_mode(s2_mode), .s2_qsel(s2_qsel),
    .s2_p(s2_p), .s2_u(s2_u), .s2_v(s2_v)
  );

  bfly_post u_post (
    .clk(clk), .rst_n(rst_n), .s2_vld(s2_vld), .s2_mode(s2_mode), .s2_qsel(s2_qsel),
    .s2_p(s2_p), .s2_u(s2_u), .s2_v(s2_v),
    .out_vld(out_vld), .out_c0(out_c0), .out_c1(out_c1)
  );

  // R8: nothing is reported in the cycle right after reset releases
  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_vld);
endmodule

// File: tb/test_ntt_bfly_unit.sv
module test_ntt_bfly_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 23;

  typedef struct packed {
    logic [1:0]   md;
    logic [1:0]   qs;
    logic [W-1:0] a0;
    logic [W-1:0] a1;
    logic [W-1:0] b0;
    logic [W-1:0] b1;
    logic [W-1:0] w;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 2'd0, 23'd3328,    23'd3328,    23'd0,       23'd0,       23'd3328},
    '{2'd0, 2'd1, 23'd8380416, 23'd8380416, 23'd0,       23'd0,       23'd8380416},
    '{2'd0, 2'd2, 23'd0,       23'd12288,   23'd0,       23'd0,       23'd1},
    '{2'd1, 2'd0, 23'd1,       23'd0,       23'd0,       23'd0,       23'd17},
    '{2'd1, 2'd1, 23'd8380416, 23'd1,       23'd0,       23'd0,       23'd5},
    '{2'd1, 2'd2, 23'd0,       23'd1,       23'd0,       23'd0,       23'd12288},
    '{2'd2, 2'd0, 23'd3328,    23'd0,       23'd3328,    23'd0,       23'd0},
    '{2'd2, 2'd1, 23'd8380416, 23'd0,       23'd8380416, 23'd0,       23'd0},
    '{2'd2, 2'd2, 23'd12288,   23'd0,       23'd2,       23'd0,       23'd0},
    '{2'd3, 2'd0, 23'd3328,    23'd3328,    23'd3328,    23'd3328,    23'd3328},
    '{2'd3, 2'd2, 23'd12288,   23'd12288,   23'd12288,   23'd12288,   23'd12288},
    '{2'd3, 2'd1, 23'd8380416, 23'd8380416, 23'd8380416, 23'd8380416, 23'd8380416},
    '{2'd0, 2'd3, 23'd3000,    23'd3328,    23'd0,       23'd0,       23'd2000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [1:0] in_mode = '0, in_qsel = '0;
  logic [W-1:0] in_a0 = '0, in_a1 = '0, in_b0 = '0, in_b1 = '0, in_w = '0;
  logic out_vld;
  logic [W-1:0] out_c0, out_c1;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // expectation ring: slot for the operation driven 4 samplings earlier
  bit           rv  [8];
  logic [1:0]   rmd [8];
  logic [1:0]   rqs [8];
  logic [W-1:0] re0 [8];
  logic [W-1:0] re1 [8];
  int cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ntt_bfly_unit i_ntt_bfly_unit (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_mode(in_mode), .in_qsel(in_qsel),
    .in_a0(in_a0), .in_a1(in_a1), .in_b0(in_b0), .in_b1(in_b1), .in_w(in_w),
    .out_vld(out_vld), .out_c0(out_c0), .out_c1(out_c1)
  );

  function automatic longint unsigned qv(input logic [1:0] s);
    if (s == 2'd1) return 64'd8380417;
    if (s == 2'd2) return 64'd12289;
    return 64'd3329;
  endfunction

  task automatic model(input vec_t v, output logic [W-1:0] e0, output logic [W-1:0] e1);
    longint unsigned q, a0, a1, b0, b1, w, i2, t;
    q = qv(v.qs); a0 = v.a0; a1 = v.a1; b0 = v.b0; b1 = v.b1; w = v.w;
    i2 = (q + 1) / 2;
    case (v.md)
      2'd0: begin
        t = (a1 * w) % q;
        e0 = W'((a0 + t) % q);
        e1 = W'((a0 + q - t) % q);
      end
      2'd1: begin
        e0 = W'((((a0 + a1) % q) * i2) % q);
        t = (w * ((a0 + q - a1) % q)) % q;
        e1 = W'((t * i2) % q);
      end
      2'd2: begin
        e0 = W'((a0 * b0) % q);
        e1 = '0;
      end
      default: begin
        t = (((a1 * b1) % q) * w) % q;
        e0 = W'(((a0 * b0) % q + t) % q);
        e1 = W'((a0 * b1 + a1 * b0) % q);
      end
    endcase
  endtask

  function automatic string tag_of(input logic [1:0] md, input logic [1:0] qs);
    string s;
    case (md)
      2'd0: s = "R1";
      2'd1: s = "R2";
      2'd2: s = "R3";
      default: s = "R4";
    endcase
    if (qs == 2'd3) s = {s, "/R5"};
    return {s, "/R6"};
  endfunction

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ring_clear();
    for (int i = 0; i < 8; i++) rv[i] = 1'b0;
    cnt = 0;
  endtask

  // one cycle: compare what is due now, then drive the next operation
  task automatic step(input vec_t v, input bit vl);
    int so;
    int si;
    logic [W-1:0] e0, e1;
    @(negedge clk);
    if (cnt >= 4) begin
      so = (cnt - 4) % 8;
      if (rv[so]) begin
        check(out_vld == 1'b1, tag_of(rmd[so], rqs[so]), out_vld, 1);
        check(out_c0 == re0[so], tag_of(rmd[so], rqs[so]), out_c0, re0[so]);
        check(out_c1 == re1[so], tag_of(rmd[so], rqs[so]), out_c1, re1[so]);
        check(out_c0 < W'(qv(rqs[so])) && out_c1 < W'(qv(rqs[so])), "R7",
              out_c0, qv(rqs[so]));
      end else begin
        check(out_vld == 1'b0, "R9", out_vld, 0);
      end
    end
    si = cnt % 8;
    model(v, e0, e1);
    rv[si] = vl; rmd[si] = v.md; rqs[si] = v.qs; re0[si] = e0; re1[si] = e1;
    in_vld = vl; in_mode = v.md; in_qsel = v.qs;
    in_a0 = v.a0; in_a1 = v.a1; in_b0 = v.b0; in_b1 = v.b1; in_w = v.w;
    cnt++;
  endtask

  function automatic vec_t rand_vec(input logic [1:0] md, input logic [1:0] qs);
    vec_t v;
    longint unsigned q;
    q = qv(qs);
    v.md = md; v.qs = qs;
    v.a0 = W'(longint'($urandom) % q);
    v.a1 = W'(longint'($urandom) % q);
    v.b0 = W'(longint'($urandom) % q);
    v.b1 = W'(longint'($urandom) % q);
    v.w  = W'(longint'($urandom) % q);
    return v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    vec_t idle;
    vec_t junk;
    idle = '0;
    junk = '{2'd3, 2'd1, 23'd77, 23'd88, 23'd99, 23'd11, 23'd22};
    void'($urandom(7));

    // R8: held in reset with valid operations offered
    in_vld = 1'b1; in_a0 = 23'd5;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(out_vld == 1'b0, "R8", out_vld, 0);
    in_vld = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_vld == 1'b0, "R8", out_vld, 0);
    ring_clear();

    // directed table
    for (int i = 0; i < NV; i++) step(TBL[i], 1'b1);
    for (int i = 0; i < 4; i++) step(idle, 1'b0);

    // R9: idle cycles carrying junk data
    for (int i = 0; i < 6; i++) step(junk, 1'b0);
    for (int i = 0; i < 4; i++) step(idle, 1'b0);

    // random operands, every mode and every modulus select
    for (int md = 0; md < 4; md++) begin
      for (int qs = 0; qs < 4; qs++) begin
        for (int k = 0; k < 24; k++) begin
          step(rand_vec(2'(md), 2'(qs)), (k % 7) != 6);
        end
      end
    end
    for (int i = 0; i < 4; i++) step(idle, 1'b0);

    // R8: reset in the middle of a full pipeline discards everything
    for (int i = 0; i < 4; i++) step(rand_vec(2'd0, 2'd1), 1'b1);
    @(negedge clk);
    in_vld = 1'b0;
    rst_n = 1'b0;
    #1;
    check(out_vld == 1'b0, "R8", out_vld, 0);
    @(negedge clk);
    rst_n = 1'b1;
    ring_clear();
    for (int i = 0; i < 5; i++) step(idle, 1'b0);

    // back-to-back after reset, R5 alias against code 0
    step('{2'd3, 2'd3, 23'd1234, 23'd2222, 23'd3000, 23'd17, 23'd3328}, 1'b1);
    step('{2'd3, 2'd0, 23'd1234, 23'd2222, 23'd3000, 23'd17, 23'd3328}, 1'b1);
    step('{2'd1, 2'd3, 23'd3327, 23'd2, 23'd0, 23'd0, 23'd1}, 1'b1);
    for (int i = 0; i < 5; i++) step(idle, 1'b0);

    finish_run();
  end
endmodule